// File: doc/BRIEF.md
# Mode-Selected Arithmetic/Logic Unit

This block is a combinational arithmetic/logic unit with a parameterised width. The default width is 4 bits. It takes two operand words, a carry input, a mode line and a two-bit function code. It returns a result word and a carry output.

In arithmetic mode, the function code picks one of four words to feed the adder: zero, the second operand, the inverted second operand, or all ones. That word is added to the first operand and the carry input through a ripple chain of full adders. Each full adder is built from two half adders. Transfer, increment, add, subtract and decrement all come out of this one adder, depending on the function code and the carry input.

In logic mode, the function code picks one bitwise operation. The mode line chooses which of the two paths drives the result.

Top module: `alu_mode_sel`

## Requirements
- R1: With mode=0 and func=00, result = (opa + carry_in) mod 2^W. This is a transfer when carry_in=0 and an increment when carry_in=1.
- R2: With mode=0 and func=01, {carry_out, result} = opa + opb + carry_in.
- R3: With mode=0 and func=10, {carry_out, result} = opa + ~opb + carry_in. With carry_in=1 this is opa - opb, and carry_out=1 exactly when opa >= opb (no borrow).
- R4: With mode=0 and func=11, {carry_out, result} = opa + (2^W - 1) + carry_in. This is a decrement when carry_in=0 and a transfer of opa with carry_out=1 when carry_in=1.
- R5: In arithmetic mode, carry_out is the carry leaving the most significant bit. For example, opa=all ones plus one wraps result to 0 and sets carry_out.
- R6: With mode=1, func selects the bitwise operation: 00 is opa AND opb, 01 is OR, 10 is XOR, and 11 is NOT opa.
- R7: With mode=1, carry_out is 0 and carry_in has no effect on result.
- R8: opb has no effect on result or carry_out for arithmetic func=00, arithmetic func=11, and logic func=11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W | First operand |
| opb | input | W | Second operand, conditioned before the adder |
| carry_in | input | 1 | Carry into bit 0 of the adder |
| mode | input | 1 | 0 = arithmetic path, 1 = logic path |
| func | input | 2 | Operation code within the selected path |
| result | output | W | Selected result word |
| carry_out | output | 1 | Adder carry from the top bit; 0 in logic mode |

## Verification
The hardest cases to reach are the full-length carry ripples. Examples are all ones plus carry_in, or subtracting equal operands, where a carry must travel through every slice and still show up correctly at carry_out. The bench sweeps every combination of both operands, carry_in, mode and func at the default width, which is 4096 vectors. Each vector is compared with a result computed arithmetically, so every ripple length is covered, including the longest. Directed vectors then repeat the wrap and equal-operand subtraction cases and change opb alone, to show that it has no effect where it should not.

// File: rtl/alu_mode_sel.sv
module alu_mode_sel #(
  parameter int W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         carry_in,
  input  logic         mode,
  input  logic [1:0]   func,
  output logic [W-1:0] result,
  output logic         carry_out
);

  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] bsel;
  logic [W-1:0] sum;
  logic [W:0]   cy;
  logic [W-1:0] lres;

  always_comb begin
    case (func)
      2'b00:   bsel = '0;
      2'b01:   bsel = opb;
      2'b10:   bsel = ~opb;
      default: bsel = ONES;
    endcase
  end

  assign cy[0] = carry_in;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic hs, hc, hc2;
    assign hs        = opa[i] ^ bsel[i];
    assign hc        = opa[i] & bsel[i];
    assign sum[i]    = hs ^ cy[i];
    assign hc2       = hs & cy[i];
    assign cy[i+1]   = hc | hc2;
  end

  always_comb begin
    case (func)
      2'b00:   lres = opa & opb;
      2'b01:   lres = opa | opb;
      2'b10:   lres = opa ^ opb;
      default: lres = ~opa;
    endcase
  end

  assign result    = mode ? lres : sum;
  assign carry_out = mode ? 1'b0 : cy[W];

  always_comb begin
    if (!$isunknown({opa, opb, carry_in, mode, func})) begin
      if (!mode && func == 2'b00 && !carry_in)
        AST_TRANSFER_A: assert (result == opa && !carry_out); // R1
      if (!mode && func == 2'b01)
        AST_ADD_SUM: assert ({carry_out, result} == {1'b0, opa} + {1'b0, opb} + (W+1)'(carry_in)); // R2
      if (!mode && func == 2'b10 && carry_in)
        AST_SUB_BORROW: assert (carry_out == (opa >= opb)); // R3
      if (!mode && func == 2'b11 && carry_in)
        AST_DEC_PASS: assert (result == opa && carry_out); // R4
      if (mode && func == 2'b11)
        AST_NOT_A: assert (result == ~opa); // R6
      if (mode)
        AST_LOGIC_NO_CARRY: assert (!carry_out); // R7
    end
  end

endmodule

// File: tb/tb_alu_mode_sel.sv
`timescale 1ns/1ps
module tb_alu_mode_sel;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] opa, opb, result;
  logic         carry_in, mode, carry_out;
  logic [1:0]   func;
  int checks = 0;
  int errors = 0;

  alu_mode_sel #(.W(W)) dut (
    .opa(opa), .opb(opb), .carry_in(carry_in), .mode(mode), .func(func),
    .result(result), .carry_out(carry_out)
  );

  function automatic string req_of(input logic md, input logic [1:0] f);
    if (md) return "R6";
    case (f)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input int a, input int b, input int c, input int md, input int f);
    @(negedge clk);
    opa = a[W-1:0]; opb = b[W-1:0]; carry_in = c[0]; mode = md[0]; func = f[1:0];
    #5;
  endtask

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (a=%0d b=%0d cin=%0d mode=%0d func=%0d)",
               req, got, exp, opa, opb, carry_in, mode, func);
    end
  endtask

  function automatic int model(input int a, input int b, input int c, input int md, input int f);
    int bc, s;
    if (md != 0) begin
      case (f)
        0: return a & b;
        1: return a | b;
        2: return a ^ b;
        default: return (~a) & M;
      endcase
    end
    case (f)
      0: bc = 0;
      1: bc = b;
      2: bc = (~b) & M;
      default: bc = M;
    endcase
    s = a + bc + c;
    return s;
  endfunction

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e;
    apply(0, 0, 0, 0, 0);
    check("R1", {27'd0, carry_out, result}, 0);

    for (int md = 0; md < 2; md++)
      for (int f = 0; f < 4; f++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a <= M; a++)
            for (int b = 0; b <= M; b++) begin
              apply(a, b, c, md, f);
              e = model(a, b, c, md, f);
              check(req_of(md[0], f[1:0]), int'(result), e & M);
              if (md != 0) check("R7", int'(carry_out), 0);
              else check("R5", int'(carry_out), (e >> W) & 1);
            end

    apply(M, 0, 1, 0, 0);
    check("R5", {27'd0, carry_out, result}, M + 1);
    apply(9, 9, 1, 0, 2);
    check("R3", {27'd0, carry_out, result}, M + 1);
    apply(3, 4, 1, 0, 2);
    check("R3", int'(carry_out), 0);
    apply(0, 5, 0, 0, 3);
    check("R4", {27'd0, carry_out, result}, M);
    apply(6, 3, 0, 1, 2);
    check("R7", int'(result), 5);
    apply(6, 3, 1, 1, 2);
    check("R7", {27'd0, carry_out, result}, 5);
    for (int f = 0; f < 4; f++) begin
      int md;
      int r0;
      if (f == 1 || f == 2) continue;
      md = (f == 3) ? 1 : 0;
      apply(10, 0, 1, md, f);
      r0 = {27'd0, carry_out, result};
      apply(10, M, 1, md, f);
      check("R8", {27'd0, carry_out, result}, r0);
    end
    apply(10, 0, 0, 0, 3);
    e = int'({carry_out, result});
    apply(10, 7, 0, 0, 3);
    check("R8", {27'd0, carry_out, result}, e);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule